// File: doc/BRIEF.md
# Self-Rearming Burst Read Engine

This block is a read-only memory master that keeps a downstream FIFO supplied from a region of external memory. The region is filled with samples in advance. Software sets a start address, a region size in bytes and an enable. After that it takes no further part. The engine starts bursts on its own, one after another, for as long as the enable stays high.

Each burst is a fixed-length incrementing request on the AXI4 read address channel. It is followed by the matching data beats on the read data channel, and each beat is pushed straight into the write port of an external FIFO. A new burst starts only when the write-side fill count of that FIFO reads zero, so returning data can never overrun it. When a burst ends at the end of the region, the next one starts again at the region's start address.

Top module: `burst_rd_dma`

## Requirements
- R1: While reset is held, and on leaving it, `ar_valid`, `r_ready`, `fifo_wr_en` and `err_flag` are all 0.
- R2: Every request carries `ar_len` = BURST_LEN-1 (15 by default), `ar_size` = log2 of the bytes per beat (3 for a 64-bit bus), `ar_burst` = 2'b01 (incrementing) and `ar_id` = ID_VAL (0 by default).
- R3: A request is raised only from the idle state, only while `cfg_en` is high, and only when `fifo_wr_count` sampled at the launching edge is exactly zero. A nonzero count holds the engine idle indefinitely.
- R4: Once `ar_valid` is high, it stays high, with `ar_addr` unchanged, until the cycle in which `ar_ready` is seen.
- R5: At most one burst is in flight. `r_ready` is high from the cycle after the request is accepted until the beat with `r_last` is accepted. `ar_valid` and `r_ready` are never high together.
- R6: In every cycle with `r_valid` and `r_ready` both high, `fifo_wr_en` is high and `fifo_wr_data` equals `r_data` in that same cycle. In no other cycle is `fifo_wr_en` high.
- R7: Successive request addresses are `cfg_base` + k·BURST_LEN·(DATA_W/8), with k starting at 0. When the next offset would reach `cfg_len` or beyond, it returns to `cfg_base`.
- R8: Dropping `cfg_en` during a burst lets that burst run to its last beat, after which no new request is raised. Re-enabling starts again at `cfg_base`.
- R9: A beat accepted with `r_resp` ≠ 0 sets `err_flag`, which then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Run enable |
| cfg_base | input | ADDR_W | Region start byte address |
| cfg_len | input | ADDR_W | Region size in bytes |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_addr | output | ADDR_W | Burst start address |
| ar_len | output | 8 | Beats minus one |
| ar_size | output | 3 | Beat size code |
| ar_burst | output | 2 | Burst type (incrementing) |
| ar_id | output | ID_W | Transaction ID |
| r_valid | input | 1 | Read data valid |
| r_ready | output | 1 | Read data ready |
| r_data | input | DATA_W | Read data |
| r_resp | input | 2 | Read response |
| r_last | input | 1 | Last beat of burst |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | DATA_W | FIFO write data |
| fifo_wr_count | input | CNT_W | FIFO write-side fill count |
| err_flag | output | 1 | Sticky read error |

## Verification
The region check assumes three things: `cfg_base` and `cfg_len` stay constant while `cfg_en` is high, `cfg_len` is a nonzero multiple of the burst size in bytes, and the memory side returns exactly BURST_LEN beats with `r_last` on the final one. The memory model in the stimulus always returns full bursts. It changes the configuration only while the enable is low and the engine is idle, and it uses only region sizes that are whole numbers of bursts. Handshake delays and gaps between beats vary from test to test, so the hold and single-burst rules are tested under backpressure.

// File: rtl/burst_rd_dma.sv
module burst_rd_dma #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int BURST_LEN = 16,
  parameter int ID_W      = 4,
  parameter int ID_VAL    = 0,
  parameter int CNT_W     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_len,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [7:0]        ar_len,
  output logic [2:0]        ar_size,
  output logic [1:0]        ar_burst,
  output logic [ID_W-1:0]   ar_id,
  input  logic              r_valid,
  output logic              r_ready,
  input  logic [DATA_W-1:0] r_data,
  input  logic [1:0]        r_resp,
  input  logic              r_last,
  output logic              fifo_wr_en,
  output logic [DATA_W-1:0] fifo_wr_data,
  input  logic [CNT_W-1:0]  fifo_wr_count,
  output logic              err_flag
);
  localparam int BYTES       = DATA_W / 8;
  localparam int SIZE_CODE   = $clog2(BYTES);
  localparam int BURST_BYTES = BURST_LEN * BYTES;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} st_t;

  st_t               st;
  logic [ADDR_W-1:0] offs;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] offs_nx;
  logic              beat;

  assign ar_valid     = (st == S_ADDR);
  assign r_ready      = (st == S_DATA);
  assign ar_addr      = addr_q;
  assign ar_len       = 8'(BURST_LEN - 1);
  assign ar_size      = 3'(SIZE_CODE);
  assign ar_burst     = 2'b01;
  assign ar_id        = ID_W'(ID_VAL);
  assign beat         = r_valid && r_ready;
  assign fifo_wr_en   = beat;
  assign fifo_wr_data = r_data;
  assign offs_nx      = (offs + STEP >= cfg_len) ? '0 : offs + STEP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      offs     <= '0;
      addr_q   <= '0;
      err_flag <= 1'b0;
    end else begin
      if (beat && r_resp != 2'b00) err_flag <= 1'b1;
      case (st)
        S_IDLE: begin
          if (!cfg_en) offs <= '0;
          else if (fifo_wr_count == '0) begin
            addr_q <= cfg_base + offs;
            st     <= S_ADDR;
          end
        end
        S_ADDR: if (ar_ready) st <= S_DATA;
        S_DATA: begin
          if (beat && r_last) begin
            offs <= offs_nx;
            st   <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r4_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr));

  a_r3_start_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ar_valid) |-> ($past(fifo_wr_count) == '0) && $past(cfg_en));

  a_r5_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    !(ar_valid && r_ready));

  a_r5_accept_opens_data: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid && ar_ready |=> r_ready);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  a_r7_addr_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ar_valid) |-> (ar_addr - cfg_base) < cfg_len);
endmodule

// File: tb/burst_rd_dma_tb_top.sv
module burst_rd_dma_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_en = 0;
  logic [31:0] cfg_base = 0, cfg_len = 32'h80;
  logic        ar_valid, ar_ready = 0;
  logic [31:0] ar_addr;
  logic [7:0]  ar_len;
  logic [2:0]  ar_size;
  logic [1:0]  ar_burst;
  logic [3:0]  ar_id;
  logic        r_valid = 0, r_ready, r_last = 0;
  logic [63:0] r_data = 0;
  logic [1:0]  r_resp = 0;
  logic        fifo_wr_en;
  logic [63:0] fifo_wr_data;
  logic [9:0]  fifo_wr_count = 0;
  logic        err_flag;

  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  burst_rd_dma dut_i (.*);

  localparam int NV = 4;
  localparam logic [31:0] V_BASE [NV] = '{32'h0000_1000, 32'h8000_0000, 32'h0004_0000, 32'hFFFF_FE00};
  localparam logic [31:0] V_LEN  [NV] = '{32'h200, 32'h80, 32'h300, 32'h200};
  localparam int          V_ARD  [NV] = '{0, 2, 1, 3};
  localparam int          V_GAP  [NV] = '{0, 1, 0, 2};

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_ar(output logic [31:0] a, output bit ok);
    ok = 0; a = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (ar_valid) begin ok = 1; a = ar_addr; return; end
    end
  endtask

  task automatic serve(input int ard, input int gap, input int err_beat, input int drop_beat,
                       output logic [31:0] a);
    bit ok;
    wait_ar(a, ok);
    chk(ok, "R3 request launched", ok, 1);
    if (!ok) return;
    for (int d = 0; d < ard; d++) begin
      @(negedge clk);
      chk(ar_valid && ar_addr == a, "R4 held until ready", {ar_valid, ar_addr}, {1'b1, a});
    end
    ar_ready = 1;
    @(negedge clk);
    ar_ready = 0;
    chk(r_ready && !ar_valid, "R5 data phase open", {r_ready, ar_valid}, 2'b10);
    for (int i = 0; i < 16; i++) begin
      for (int g = 0; g < gap; g++) begin
        r_valid = 0; #1;
        chk(!fifo_wr_en && r_ready, "R6 no push without beat", fifo_wr_en, 0);
        @(negedge clk);
      end
      r_valid = 1;
      r_data  = {32'(i) ^ 32'hA5A5_0000, a + 32'(i * 8)};
      r_last  = (i == 15);
      r_resp  = (i == err_beat) ? 2'b10 : 2'b00;
      if (i == drop_beat) cfg_en = 0;
      #1;
      chk(fifo_wr_en && fifo_wr_data == r_data, "R6 beat pushed", fifo_wr_data, r_data);
      @(negedge clk);
    end
    r_valid = 0; r_last = 0; r_resp = 0;
  endtask

  initial begin
    #(20 * 150000);
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] a;
    bit ok;
    repeat (4) @(negedge clk);
    chk(!ar_valid && !r_ready && !fifo_wr_en && !err_flag, "R1 reset outputs",
        {ar_valid, r_ready, fifo_wr_en, err_flag}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!ar_valid && !r_ready && !err_flag, "R1 after reset", {ar_valid, r_ready, err_flag}, 0);

    for (int v = 0; v < NV; v++) begin
      cfg_en = 0;
      cfg_base = V_BASE[v];
      cfg_len  = V_LEN[v];
      repeat (2) @(negedge clk);
      cfg_en = 1;
      for (int b = 0; b <= int'(V_LEN[v] / 128); b++) begin
        serve(V_ARD[v], V_GAP[v], -1, -1, a);
        chk(a == V_BASE[v] + (32'(b) * 128) % V_LEN[v], "R7 address sequence", a,
            V_BASE[v] + (32'(b) * 128) % V_LEN[v]);
        if (b == 0)
          chk(ar_len == 15 && ar_size == 3 && ar_burst == 2'b01 && ar_id == 0, "R2 request fields",
              {ar_len, ar_size, ar_burst, ar_id}, {8'd15, 3'd3, 2'b01, 4'd0});
      end
    end
    cfg_en = 0;
    chk(!err_flag, "R9 no error on clean data", err_flag, 0);

    cfg_base = 32'h2000; cfg_len = 32'h400;
    fifo_wr_count = 7;
    @(negedge clk);
    cfg_en = 1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(!ar_valid, "R3 nonzero count holds idle", ar_valid, 0);
    end
    fifo_wr_count = 1;
    repeat (3) @(negedge clk);
    chk(!ar_valid, "R3 count of one holds idle", ar_valid, 0);
    fifo_wr_count = 0;
    serve(0, 0, -1, -1, a);
    chk(a == 32'h2000, "R3 starts once count is zero", a, 32'h2000);

    serve(1, 0, -1, 5, a);
    chk(a == 32'h2080, "R8 burst before drop", a, 32'h2080);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(!ar_valid, "R8 idle after enable drop", ar_valid, 0);
    end
    cfg_en = 1;
    serve(0, 0, -1, -1, a);
    chk(a == 32'h2000, "R8 restart at base", a, 32'h2000);

    serve(0, 0, 3, -1, a);
    chk(err_flag, "R9 error set", err_flag, 1);
    serve(0, 1, -1, -1, a);
    chk(err_flag, "R9 error sticky", err_flag, 1);
    cfg_en = 0;
    wait_ar(a, ok);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!err_flag && !ar_valid, "R1 R9 reset clears error", {err_flag, ar_valid}, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule